// File: doc/BRIEF.md
# Byte-Wide Host Bus Slave Port

This block is the device side of an 8-bit asynchronous parallel host bus. The bus has an active-low chip select, an active-low data strobe, a read/not-write line, a two-bit register address and a byte-wide data path. The block brings the three control lines into the system clock domain through flop synchronisers and finds their edges there. It takes the register address from the pins at the moment chip select falls, and that address holds for the whole access.

Two registers sit behind the port. The first is a one-byte control register that the host reads and writes directly. The second is a mailbox that carries 32-bit message words as four bytes, most significant byte first. A complete word written by the host appears on the internal side as a one-cycle valid pulse once chip select has risen. A word offered on the internal side is returned to the host one byte per strobe.

The block presents the data path as a byte output plus an output-enable. The pad ring turns these into a tri-stated bus.

Top module: `hbp_port`

## Requirements
- R1: While reset is high and on the first cycle after it, `bus_doe`, `msg_wr_valid` and `msg_err` are 0, and `ctrl_reg` and `msg_wr_data` are cleared to zero.
- R2: The register address is taken from `bus_addr` when the synchronised chip select falls. Changes on `bus_addr` later in the same access have no effect.
- R3: During a write to address 00, each synchronised strobe rising edge takes one byte from `bus_din`. The first byte lands in bits 31:24 and the fourth in bits 7:0.
- R4: A four-byte message word is published on `msg_wr_data` with `msg_wr_valid` high for exactly one cycle. This happens only after chip select has risen, so the pulse never occurs while the bus is being driven.
- R5: `bus_doe` is 1 only while the synchronised chip select and strobe are both low and read/not-write is high. `bus_dout` is 8'h00 whenever `bus_doe` is 0. Each control input reaches the outputs on the third rising clock edge after it changes.
- R6: Address 01 is the control byte. A write strobe stores `bus_din` in `ctrl_reg`, and a read drives `ctrl_reg` onto `bus_dout`.
- R7: A read at address 00 returns the bytes of `msg_rd_data` most significant first, advancing one byte per strobe rising edge. After the fourth byte it drives 8'h00.
- R8: If chip select rises after one to three bytes have been written to address 00, the partial word is discarded. In that case `msg_wr_data` keeps its previous value, no valid pulse is given, and `msg_err` is set and stays set until reset.
- R9: Write bytes beyond the fourth in one access to address 00 are ignored. The word delivered is made of the first four bytes.
- R10: Addresses 10 and 11 are unmapped. Writes to them change neither register, and reads from them drive 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Host chip select, active low, asynchronous |
| bus_strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| bus_rnw | input | 1 | High for read, low for write |
| bus_addr | input | 2 | Register address, captured when chip select falls |
| bus_din | input | 8 | Byte from the host |
| bus_dout | output | 8 | Byte to the host |
| bus_doe | output | 1 | Output enable for the host data pads |
| ctrl_reg | output | 8 | Control byte register |
| msg_wr_valid | output | 1 | One-cycle pulse: a new message word is on msg_wr_data |
| msg_wr_data | output | 32 | Last complete message word from the host |
| msg_rd_data | input | 32 | Message word offered to host reads |
| msg_err | output | 1 | Sticky flag for a truncated message write |

## Verification
Several properties are checked by assertions on every cycle. The address stays constant except at a chip-select fall. The write byte counter never passes four. A valid pulse lasts exactly one cycle and never coincides with the bus being driven. The error flag never clears outside reset, and no valid pulse accompanies it when it rises.

Other behaviour can only be shown by the bench's scenarios against its cycle-level model. This covers the byte order of assembled and returned words, the discarding of a partial word, the ignoring of surplus bytes, the effect of moving the address mid-access, and the behaviour of unmapped addresses.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef enum logic [1:0] {
    SEL_MSG   = 2'b00,
    SEL_CTRL  = 2'b01,
    SEL_SPARE = 2'b10,
    SEL_NONE  = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int              WIDTH  = 3,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] INIT  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbp_wr_asm.sv
module hbp_wr_asm #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               finish,
  input  logic               byte_stb,
  input  logic [7:0]         byte_in,
  output logic               word_valid,
  output logic [8*BYTES-1:0] word,
  output logic               err
);
  localparam int CW = $clog2(BYTES + 1);

  logic [CW-1:0]      cnt;
  logic [8*BYTES-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      shadow     <= '0;
      word       <= '0;
      word_valid <= 1'b0;
      err        <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (start) begin
        cnt <= '0;
      end else if (byte_stb && cnt < CW'(BYTES)) begin
        for (int b = 0; b < BYTES; b++)
          if (cnt == CW'(b)) shadow[(BYTES-1-b)*8 +: 8] <= byte_in;
        cnt <= cnt + CW'(1);
      end
      if (finish) begin
        if (cnt == CW'(BYTES)) begin
          word       <= shadow;
          word_valid <= 1'b1;
        end else if (cnt != '0) begin
          err <= 1'b1;
        end
      end
    end
  end

  AST_WR_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(BYTES)); // R9
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst) word_valid |=> !word_valid); // R4
  AST_ERR_STICKY:   assert property (@(posedge clk) disable iff (rst) err |=> err); // R8
  AST_ERR_NO_WORD:  assert property (@(posedge clk) disable iff (rst) $rose(err) |-> !word_valid); // R8
endmodule

// File: rtl/hbp_rd_sel.sv
module hbp_rd_sel #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               adv,
  input  logic [8*BYTES-1:0] word,
  output logic [7:0]         byte_out
);
  localparam int CW = $clog2(BYTES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                              cnt <= '0;
    else if (start)                       cnt <= '0;
    else if (adv && cnt < CW'(BYTES))     cnt <= cnt + CW'(1);
  end

  always_comb begin
    byte_out = 8'h00;
    for (int b = 0; b < BYTES; b++)
      if (cnt == CW'(b)) byte_out = word[(BYTES-1-b)*8 +: 8];
  end

  AST_RD_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(BYTES)); // R7
endmodule

// File: rtl/hbp_port.sv
module hbp_port
  import hbp_pkg::*;
#(
  parameter int BYTES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel_n,
  input  logic               bus_strobe_n,
  input  logic               bus_rnw,
  input  logic [1:0]         bus_addr,
  input  logic [7:0]         bus_din,
  output logic [7:0]         bus_dout,
  output logic               bus_doe,
  output logic [7:0]         ctrl_reg,
  output logic               msg_wr_valid,
  output logic [8*BYTES-1:0] msg_wr_data,
  input  logic [8*BYTES-1:0] msg_rd_data,
  output logic               msg_err
);
  logic [2:0] s_ctl;
  logic       s_cs_n, s_ds_n, s_rnw;
  logic       p_cs_n, p_ds_n;
  logic       cs_fall, cs_rise, ds_rise, wr_stb, rd_stb, drive;
  reg_sel_e   sel_q;
  logic [7:0] msg_byte, rd_mux;

  hbp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_rnw, bus_strobe_n, bus_sel_n}),
    .q   (s_ctl)
  );
  assign {s_rnw, s_ds_n, s_cs_n} = s_ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_cs_n <= 1'b1;
      p_ds_n <= 1'b1;
    end else begin
      p_cs_n <= s_cs_n;
      p_ds_n <= s_ds_n;
    end
  end

  assign cs_fall = p_cs_n & ~s_cs_n;
  assign cs_rise = ~p_cs_n & s_cs_n;
  assign ds_rise = ~s_cs_n & ~p_ds_n & s_ds_n;
  assign wr_stb  = ds_rise & ~s_rnw;
  assign rd_stb  = ds_rise & s_rnw;
  assign drive   = ~s_cs_n & ~s_ds_n & s_rnw;

  always_ff @(posedge clk) begin
    if (rst)          sel_q <= SEL_MSG;
    else if (cs_fall) sel_q <= reg_sel_e'(bus_addr);
  end

  always_ff @(posedge clk) begin
    if (rst)                            ctrl_reg <= 8'h00;
    else if (wr_stb && sel_q == SEL_CTRL) ctrl_reg <= bus_din;
  end

  hbp_wr_asm #(.BYTES(BYTES)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .start      (cs_fall),
    .finish     (cs_rise),
    .byte_stb   (wr_stb && sel_q == SEL_MSG),
    .byte_in    (bus_din),
    .word_valid (msg_wr_valid),
    .word       (msg_wr_data),
    .err        (msg_err)
  );

  hbp_rd_sel #(.BYTES(BYTES)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .start    (cs_fall),
    .adv      (rd_stb && sel_q == SEL_MSG),
    .word     (msg_rd_data),
    .byte_out (msg_byte)
  );

  always_comb begin
    case (sel_q)
      SEL_MSG:  rd_mux = msg_byte;
      SEL_CTRL: rd_mux = ctrl_reg;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_doe  <= 1'b0;
      bus_dout <= 8'h00;
    end else begin
      bus_doe  <= drive;
      bus_dout <= drive ? rd_mux : 8'h00;
    end
  end

  AST_RST_QUIET:     assert property (@(posedge clk) rst |=> (!bus_doe && !msg_wr_valid && !msg_err)); // R1
  AST_ADDR_HOLD:     assert property (@(posedge clk) disable iff (rst) !cs_fall |=> $stable(sel_q)); // R2
  AST_DELIVER_IDLE:  assert property (@(posedge clk) disable iff (rst) msg_wr_valid |-> !bus_doe); // R4
  AST_QUIET_DATA:    assert property (@(posedge clk) disable iff (rst) !bus_doe |-> bus_dout == 8'h00); // R5
endmodule

// File: tb/sim_hbp_port.sv
module sim_hbp_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ds_n = 1'b1, rnw = 1'b1;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  din = 8'h00;
  logic [31:0] rd_word = 32'h0;
  logic [7:0]  dout, ctrl;
  logic        doe, wvalid, err;
  logic [31:0] wdata;

  int n_run = 0, n_fail = 0, n_valid = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hbp_port u0 (
    .clk(clk), .rst(rst), .bus_sel_n(cs_n), .bus_strobe_n(ds_n), .bus_rnw(rnw),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_doe(doe),
    .ctrl_reg(ctrl), .msg_wr_valid(wvalid), .msg_wr_data(wdata),
    .msg_rd_data(rd_word), .msg_err(err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: control lines delayed through a sample history
  bit [2:0] h_cs = '1, h_ds = '1, h_rn = '1;
  logic [1:0]  m_addr;
  int          m_wcnt, m_rcnt;
  logic [31:0] m_asm, m_word;
  logic [7:0]  m_ctrl, m_dout, mux;
  logic        m_doe, m_valid, m_err;

  always @(posedge clk) begin
    if (rst) begin
      h_cs = '1; h_ds = '1; h_rn = '1;
      m_addr = 0; m_wcnt = 0; m_rcnt = 0; m_asm = 0; m_word = 0;
      m_ctrl = 0; m_dout = 0; m_doe = 0; m_valid = 0; m_err = 0;
    end else begin
      if (m_addr == 2'b01) mux = m_ctrl;
      else if (m_addr == 2'b00) mux = (m_rcnt < 4) ? rd_word[31-8*m_rcnt -: 8] : 8'h00;
      else mux = 8'h00;
      m_doe   = !h_cs[1] && !h_ds[1] && h_rn[1];
      m_dout  = m_doe ? mux : 8'h00;
      m_valid = 0;
      if (h_cs[2] && !h_cs[1]) begin
        m_addr = addr; m_wcnt = 0; m_rcnt = 0;
      end else if (!h_cs[1] && !h_ds[2] && h_ds[1]) begin
        if (!h_rn[1]) begin
          if (m_addr == 2'b00 && m_wcnt < 4) begin
            m_asm[31-8*m_wcnt -: 8] = din; m_wcnt++;
          end else if (m_addr == 2'b01) m_ctrl = din;
        end else if (m_addr == 2'b00 && m_rcnt < 4) m_rcnt++;
      end
      if (!h_cs[2] && h_cs[1] && m_addr == 2'b00) begin
        if (m_wcnt == 4) begin m_word = m_asm; m_valid = 1; end
        else if (m_wcnt != 0) m_err = 1;
      end
      h_cs = {h_cs[1:0], cs_n}; h_ds = {h_ds[1:0], ds_n}; h_rn = {h_rn[1:0], rnw};
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 doe", doe, m_doe);
      chk("R5/R7 dout", dout, m_dout);
      chk("R4 valid", wvalid, m_valid);
      chk("R3 wdata", wdata, m_word);
      chk("R6 ctrl", ctrl, m_ctrl);
      chk("R8 err", err, m_err);
      if (wvalid) begin
        n_valid++;
        chk("R4 valid only with cs high", cs_n, 1'b1);
      end
    end
  end

  task automatic wait_n(int n); repeat (n) @(negedge clk); endtask
  task automatic open_cyc(logic [1:0] a, logic r);
    addr = a; rnw = r; wait_n(2); cs_n = 0; wait_n(6);
  endtask
  task automatic close_cyc; cs_n = 1; wait_n(8); endtask
  task automatic wr_byte(logic [7:0] b);
    din = b; wait_n(1); ds_n = 0; wait_n(5); ds_n = 1; wait_n(5);
  endtask
  task automatic rd_byte(output logic [7:0] b);
    ds_n = 0; wait_n(6); b = dout; ds_n = 1; wait_n(5);
  endtask

  initial begin : main
    logic [7:0] rb;
    int v0;
    wait_n(4);
    chk("R1 doe in reset", doe, 0);
    chk("R1 ctrl in reset", ctrl, 0);
    chk("R1 err in reset", err, 0);
    chk("R1 valid in reset", wvalid, 0);
    rst = 0; wait_n(4);

    // R2 + R3: full write, address pins moved after chip select falls
    v0 = n_valid;
    open_cyc(2'b00, 0);
    addr = 2'b01;
    wr_byte(8'hA1); wr_byte(8'hB2); wr_byte(8'hC3); wr_byte(8'hD4);
    chk("R4 no delivery before cs rise", n_valid, v0);
    close_cyc;
    chk("R3 word msb first", wdata, 32'hA1B2C3D4);
    chk("R4 one pulse", n_valid, v0 + 1);
    chk("R2 ctrl untouched", ctrl, 8'h00);

    // R6: control byte write and read
    open_cyc(2'b01, 0); wr_byte(8'h5A); close_cyc;
    chk("R6 ctrl written", ctrl, 8'h5A);
    open_cyc(2'b01, 1);
    chk("R5 no drive while strobe high", doe, 0);
    rd_byte(rb); chk("R6 ctrl read", rb, 8'h5A);
    close_cyc;

    // R7: message read, five strobes, address moved mid-access
    rd_word = 32'h11223344;
    open_cyc(2'b00, 1); addr = 2'b11;
    rd_byte(rb); chk("R7 byte0", rb, 8'h11);
    rd_byte(rb); chk("R7 byte1", rb, 8'h22);
    rd_byte(rb); chk("R7 byte2", rb, 8'h33);
    rd_byte(rb); chk("R7 byte3", rb, 8'h44);
    rd_byte(rb); chk("R7 past end", rb, 8'h00);
    close_cyc;
    chk("R5 released after cycle", doe, 0);

    // R8: truncated write
    v0 = n_valid;
    open_cyc(2'b00, 0); wr_byte(8'h01); wr_byte(8'h02); close_cyc;
    chk("R8 err set", err, 1);
    chk("R8 word kept", wdata, 32'hA1B2C3D4);
    chk("R8 no pulse", n_valid, v0);

    // R9: surplus bytes
    open_cyc(2'b00, 0);
    wr_byte(8'hCA); wr_byte(8'hFE); wr_byte(8'hBA); wr_byte(8'hBE);
    wr_byte(8'h77); wr_byte(8'h88);
    close_cyc;
    chk("R9 first four kept", wdata, 32'hCAFEBABE);
    chk("R8 err still set", err, 1);

    // R10: unmapped addresses
    open_cyc(2'b10, 0); wr_byte(8'hEE); close_cyc;
    chk("R10 ctrl unchanged", ctrl, 8'h5A);
    chk("R10 word unchanged", wdata, 32'hCAFEBABE);
    open_cyc(2'b11, 1); rd_byte(rb); chk("R10 read zero", rb, 8'h00); close_cyc;

    rst = 1; wait_n(3);
    chk("R1 err cleared", err, 0);
    chk("R1 ctrl cleared", ctrl, 0);
    chk("R1 word cleared", wdata, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule